// File: doc/BRIEF.md
# Internal-Clock Serial ADC Interface Model

This block is a synthesizable, device-side model of the digital interface of an 8-channel, 12-bit serial converter that times its own conversions. A host drives a chip select (low selects), a serial clock and a data line. The host shifts in a command byte. The block then runs an acquisition phase and a conversion phase from an internal tick. That tick is a fixed division of the system clock. While both phases run, the block holds a strobe low. When the strobe returns high, the block presents a 12-bit result, most significant bit first, on its serial output.

The host first sends a command byte. The leading 1 bit marks the start of the byte. Any zeros before it are skipped. The byte then names the channel in three select bits and picks a power/clock mode in its two final bits. Only the internal-clock mode code starts a conversion. The result word comes from one of eight digital sample inputs, which stand in for the analog channels. The host may read the result at any serial clock rate. Serial inputs are brought into the system clock domain through two-flop synchronisers.

Top module: `adc_serial_emu`

## Requirements
- R1: A command byte is shifted in MSB first on serial clock rising edges while chip select is low. Its first 1 bit is the start bit, and any 0 bits before it are skipped. Bit positions, with bit 7 arriving first: 7 is start, 6..4 is the channel (bit 6 is the channel MSB), 3 is range, 2 is polarity, and 1..0 is the mode.
- R2: A conversion starts only when the mode bits 1..0 equal 00. A byte with mode 01, 10 or 11 leaves the strobe high.
- R3: The strobe goes low on the serial clock falling edge that follows the 8th command bit. After the three-cycle synchroniser and edge-detect delay, it is low within 6 system clocks of that edge.
- R4: The selected channel's sample is captured at the 4th internal tick, which is CLK_DIV*4 system clocks after the strobe falls. Later changes on the sample inputs do not alter the result.
- R5: The strobe stays low for exactly CLK_DIV*16 system clocks: 4 ticks of acquisition and 12 ticks of conversion.
- R6: When the strobe rises, the output carries result bit 11. Each serial clock falling edge with chip select low moves on to the next lower bit. After bit 0, further falling edges give 0.
- R7: While chip select is high, the output enable is low, the output is 0, and the data and serial clock lines cannot form a command. A partial byte is discarded when chip select rises.
- R8: Raising chip select during a conversion does not abort it. The strobe rises at the normal time, and the result can be read once chip select is low again.
- R9: After reset the strobe is high and the output shift register holds zero.
- R10: A command byte completed while a conversion is running is ignored. The current result is unaffected, and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select from host, low selects |
| sclk_i | input | 1 | Serial clock from host |
| din_i | input | 1 | Serial command data from host |
| samples_i | input | NUM_CH*DATA_W | Sample words, channel k at bits k*DATA_W upward |
| dout_o | output | 1 | Serial result data (0 while disabled) |
| dout_oe_o | output | 1 | Enable for the external tri-state output driver |
| strb_o | output | 1 | Low while acquiring or converting |

## Verification
A wrong phase counter shows at the ports as a strobe low period other than 16 ticks. The bench counts that period to the exact system clock on every conversion. A wrong capture point shows up as the wrong word, once the bench changes a sample input on either side of the 4th tick. A corrupted receive counter or mode decode either starts conversions that should not start, or misses ones that should. Either fault is visible within one byte time, and the bench sweeps every channel under two data patterns, varied leading zeros, and each ignored case.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2
    } conv_st_e;

    // Command byte bit positions (bit 7 arrives first)
    localparam int CMD_BITS    = 8;
    localparam int CMD_SEL_MSB = 6;
    localparam int CMD_MODE_HI = 1;
    localparam int CMD_MODE_LO = 0;
    localparam logic [1:0] MODE_INT_CLK = 2'b00;

endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, meta_d;
        logic stab_q, stab_d;

        always_comb begin
            meta_d = async_i[g];
            stab_d = meta_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= meta_d;
                stab_q <= stab_d;
            end
        end

        assign sync_o[g] = stab_q;
    end
endmodule

// File: rtl/adc_emu_tick.sv
module adc_emu_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    assign tick_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)   cnt_d = '0;
        else if (tick_o) cnt_d = '0;
        else if (run_i)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_tick_not_on_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o || (DIV == 1));
endmodule

// File: rtl/adc_emu_core.sv
module adc_emu_core
    import adc_emu_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int NUM_CH = 8,
    parameter int ACQ_P  = 4,
    parameter int CONV_P = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_s_i,
    input  logic                     sclk_s_i,
    input  logic                     din_s_i,
    input  logic [NUM_CH*DATA_W-1:0] samples_i,
    input  logic                     tick_i,
    output logic                     restart_o,
    output logic                     busy_o,
    output logic                     dout_o,
    output logic                     dout_oe_o,
    output logic                     strb_o
);
    localparam int TOTAL_P = ACQ_P + CONV_P;
    localparam int PW      = $clog2(TOTAL_P + 1);
    localparam int SEL_W   = $clog2(NUM_CH);
    localparam int RCW     = $clog2(CMD_BITS + 1);
    localparam logic [PW-1:0]  ACQ_LAST = PW'(ACQ_P - 1);
    localparam logic [PW-1:0]  END_LAST = PW'(TOTAL_P - 1);
    localparam logic [RCW-1:0] RX_FULL  = RCW'(CMD_BITS);

    typedef struct packed {
        conv_st_e              st;
        logic                  sclk_prev;
        logic [RCW-1:0]        rx_cnt;
        logic [CMD_BITS-1:0]   rx_sh;
        logic [SEL_W-1:0]      chan;
        logic [PW-1:0]         pulse;
        logic [DATA_W-1:0]     hold;
        logic [DATA_W-1:0]     outsh;
    } core_t;

    core_t r_q, r_d;

    logic [DATA_W-1:0] ch_word [NUM_CH];
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_word[g] = samples_i[g*DATA_W +: DATA_W];
    end

    logic sclk_rise, sclk_fall, byte_end;
    assign sclk_rise = sclk_s_i & ~r_q.sclk_prev;
    assign sclk_fall = ~sclk_s_i & r_q.sclk_prev;
    assign byte_end  = !cs_s_i && sclk_fall && (r_q.rx_cnt == RX_FULL);

    always_comb begin
        r_d       = r_q;
        restart_o = 1'b0;
        r_d.sclk_prev = sclk_s_i;

        if (cs_s_i) begin
            r_d.rx_cnt = '0;
        end else begin
            if (sclk_rise && (r_q.rx_cnt != RX_FULL)) begin
                if (r_q.rx_cnt == '0) begin
                    if (din_s_i) begin
                        r_d.rx_sh  = CMD_BITS'(1);
                        r_d.rx_cnt = RCW'(1);
                    end
                end else begin
                    r_d.rx_sh  = {r_q.rx_sh[CMD_BITS-2:0], din_s_i};
                    r_d.rx_cnt = r_q.rx_cnt + 1'b1;
                end
            end
            if (sclk_fall && (r_q.st == ST_IDLE)) begin
                r_d.outsh = {r_q.outsh[DATA_W-2:0], 1'b0};
            end
            if (byte_end) begin
                r_d.rx_cnt = '0;
                if ((r_q.st == ST_IDLE) &&
                    (r_q.rx_sh[CMD_MODE_HI:CMD_MODE_LO] == MODE_INT_CLK)) begin
                    r_d.st    = ST_ACQ;
                    r_d.chan  = r_q.rx_sh[CMD_SEL_MSB -: SEL_W];
                    r_d.pulse = '0;
                    restart_o = 1'b1;
                end
            end
        end

        if ((r_q.st != ST_IDLE) && tick_i) begin
            r_d.pulse = r_q.pulse + 1'b1;
            if (r_q.pulse == ACQ_LAST) begin
                r_d.hold = ch_word[r_q.chan];
                r_d.st   = ST_CONV;
            end
            if (r_q.pulse == END_LAST) begin
                r_d.outsh = r_q.hold;
                r_d.st    = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign strb_o    = ~busy_o;
    assign dout_oe_o = ~cs_s_i;
    assign dout_o    = dout_oe_o & r_q.outsh[DATA_W-1];

    assert_strb_low_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !strb_o);

    assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && strb_o && (r_q.rx_sh[CMD_MODE_HI:CMD_MODE_LO] != MODE_INT_CLK))
        |=> strb_o);

    assert_conv_after_acq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CONV) |-> (r_q.pulse > ACQ_LAST));

    assert_end_on_last_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_o) |-> $past(tick_i && (r_q.pulse == END_LAST)));

    assert_out_frozen_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(r_q.outsh));

    assert_cs_drops_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s_i |=> (r_q.rx_cnt == '0));

    assert_busy_ignores_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && busy_o) |=> $stable(r_q.chan));
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu #(
    parameter int DATA_W      = 12,
    parameter int NUM_CH      = 8,
    parameter int CLK_DIV     = 4,
    parameter int ACQ_PULSES  = 4,
    parameter int CONV_PULSES = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n_i,
    input  logic                     sclk_i,
    input  logic                     din_i,
    input  logic [NUM_CH*DATA_W-1:0] samples_i,
    output logic                     dout_o,
    output logic                     dout_oe_o,
    output logic                     strb_o
);
    logic [2:0] raw, synced;
    logic       tick, restart, busy;

    assign raw = {cs_n_i, sclk_i, din_i};

    adc_emu_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    adc_emu_tick #(.DIV(CLK_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .run_i     (busy),
        .tick_o    (tick)
    );

    adc_emu_core #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH),
        .ACQ_P  (ACQ_PULSES),
        .CONV_P (CONV_PULSES)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s_i    (synced[2]),
        .sclk_s_i  (synced[1]),
        .din_s_i   (synced[0]),
        .samples_i (samples_i),
        .tick_i    (tick),
        .restart_o (restart),
        .busy_o    (busy),
        .dout_o    (dout_o),
        .dout_oe_o (dout_oe_o),
        .strb_o    (strb_o)
    );
endmodule

// File: tb/adc_serial_emu_test.sv
module adc_serial_emu_test;
    localparam int W    = 12;
    localparam int NCH  = 8;
    localparam int DIV  = 8;
    localparam int BUSY = 16 * DIV;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, cs_n, sclk, din;
    logic [NCH*W-1:0] samples;
    logic dout, oe, strb;

    adc_serial_emu #(.DATA_W(W), .NUM_CH(NCH), .CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
        .samples_i(samples), .dout_o(dout), .dout_oe_o(oe), .strb_o(strb)
    );

    int checks = 0;
    int fails  = 0;
    int lowrun = 0;
    int last_low = 0;

    always @(posedge clk) begin
        if (!rst_n) lowrun <= 0;
        else if (strb == 1'b0) lowrun <= lowrun + 1;
        else begin
            if (lowrun != 0) last_low <= lowrun;
            lowrun <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int ch, input int p);
        logic [W-1:0] v;
        v = W'(ch * 677 + 2067);
        return (p != 0) ? ~v : v;
    endfunction

    task automatic set_all(input int p);
        for (int c = 0; c < NCH; c++) samples[c*W +: W] = pat(c, p);
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1; tick_n(4);
        sclk = 1'b0; tick_n(6);
    endtask

    task automatic send_byte(input logic [7:0] b, input int nz);
        for (int z = 0; z < nz; z++) begin
            din = 1'b0; tick_n(2); sclk_pulse();
        end
        for (int i = 7; i >= 0; i--) begin
            din = b[i]; tick_n(2); sclk_pulse();
        end
        din = 1'b0;
    endtask

    task automatic wait_strb_high();
        while (strb !== 1'b1) tick_n(1);
        tick_n(2);
    endtask

    task automatic read_word(output logic [W-1:0] w, output logic [3:0] tail);
        w[W-1] = dout;
        for (int i = W-2; i >= 0; i--) begin
            sclk_pulse();
            w[i] = dout;
        end
        for (int i = 3; i >= 0; i--) begin
            sclk_pulse();
            tail[i] = dout;
        end
    endtask

    task automatic watch_high(input int n, output bit ok);
        ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick_n(1);
            if (strb !== 1'b1) ok = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] w;
        logic [3:0]   tail;
        logic [7:0]   b;
        bit           ok;

        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
        set_all(0);
        tick_n(5);
        chk(strb === 1'b1, "R9 strb at reset", strb, 1);
        chk(oe === 1'b0, "R7 oe with cs high", oe, 0);
        rst_n = 1'b1; tick_n(5);
        cs_n = 1'b0; tick_n(4);
        chk(oe === 1'b1, "R7 oe with cs low", oe, 1);
        chk(dout === 1'b0, "R9 output register zero", dout, 0);

        // R1 R3 R4 R5 R6: every channel, two data patterns, varied leading zeros
        for (int p = 0; p < 2; p++) begin
            set_all(p);
            for (int ch = 0; ch < NCH; ch++) begin
                b = {1'b1, 3'(ch), 1'(p), 1'(~p), 2'b00};
                send_byte(b, ch % 3);
                chk(strb === 1'b0, "R3 strb low after byte", strb, 0);
                wait_strb_high();
                chk(last_low == BUSY, "R5 strb low length", last_low, BUSY);
                read_word(w, tail);
                chk(w == pat(ch, p), "R1/R4/R6 result word", w, pat(ch, p));
                chk(tail == 4'h0, "R6 zeros after D0", tail, 0);
            end
        end

        // R4: capture at the 4th tick; later sample changes ignored
        set_all(0);
        send_byte({1'b1, 3'd5, 4'b0000}, 0);
        while (lowrun < 8) tick_n(1);
        samples[5*W +: W] = 12'hA5C;
        while (lowrun < 40) tick_n(1);
        samples[5*W +: W] = 12'h3C3;
        wait_strb_high();
        read_word(w, tail);
        chk(w == 12'hA5C, "R4 capture point", w, 12'hA5C);
        set_all(0);

        // R2: non-zero mode codes start nothing
        for (int m = 1; m < 4; m++) begin
            send_byte({1'b1, 3'd2, 2'b00, 2'(m)}, 1);
            watch_high(3 * BUSY, ok);
            chk(ok, "R2 mode ignored", m, 0);
        end

        // R7: byte with cs high ignored; partial byte dropped by cs
        cs_n = 1'b1; tick_n(4);
        send_byte({1'b1, 3'd3, 4'b0000}, 0);
        chk(oe === 1'b0 && dout === 1'b0, "R7 output off with cs high", {oe, dout}, 0);
        watch_high(3 * BUSY, ok);
        chk(ok, "R7 byte with cs high", 0, 1);
        cs_n = 1'b0; tick_n(4);
        for (int i = 7; i >= 4; i--) begin din = 1'(8'hB0 >> i); tick_n(2); sclk_pulse(); end
        cs_n = 1'b1; tick_n(4); cs_n = 1'b0; tick_n(4);
        for (int i = 3; i >= 0; i--) begin din = 1'b0; tick_n(2); sclk_pulse(); end
        watch_high(3 * BUSY, ok);
        chk(ok, "R7 partial byte dropped", 0, 1);

        // R8: cs raised mid conversion
        send_byte({1'b1, 3'd2, 4'b0000}, 0);
        cs_n = 1'b1;
        wait_strb_high();
        chk(last_low == BUSY, "R8 conversion not aborted", last_low, BUSY);
        chk(oe === 1'b0, "R8 oe off while cs high", oe, 0);
        cs_n = 1'b0; tick_n(4);
        read_word(w, tail);
        chk(w == pat(2, 0), "R8 result after cs", w, pat(2, 0));

        // R10: byte finished during conversion ignored
        send_byte({1'b1, 3'd6, 4'b0000}, 0);
        send_byte({1'b1, 3'd1, 4'b0000}, 0);
        wait_strb_high();
        read_word(w, tail);
        chk(w == pat(6, 0), "R10 first result kept", w, pat(6, 0));
        watch_high(3 * BUSY, ok);
        chk(ok, "R10 no second conversion", 0, 1);

        finish_run();
    end
endmodule